// File: doc/BRIEF.md
# Mixed-Radix Bus Cycle Timer

This block keeps the free-running time word of a serial bus link layer. Three counters are chained inside one 32-bit word: a sub-cycle offset that steps once per period of the 24.576 MHz time base, a cycle count that steps each time the offset completes a 125 us cycle, and a 7-bit seconds count that steps each time the cycle count completes one second. The offset range is 3072 and the cycle range is 8000, so the word is not a plain binary counter. A reader takes the whole word in one read and can convert it to a linear tick count as offset + 3072 * count + 24,576,000 * seconds.

All three fields are registers that change on the same clock edge. A carry out of one field therefore shows up in the next field in the same update. A reader never sees a torn low field, and never sees an offset that has wrapped while the cycle count lags behind. A load strobe lets software or a cycle master write the whole word at once. Out-of-range field values in a load are forced to zero. Single-clock pulses mark cycle and second boundaries for the logic that sends cycle-start packets.

Top module: `bus_cycle_timer`

## Requirements
- R1: While `rst` is high, `timer`, `cycle_start` and `second_start` are all zero on the following clock.
- R2: The offset field `timer[11:0]` rises by one on each clock with `tick_en` high and `load` low. From 3071 it returns to 0.
- R3: On a clock with `tick_en` low and `load` low, `timer` keeps its value.
- R4: The count field `timer[24:12]` rises by one in the same update in which the offset returns from 3071 to 0. From 7999 it returns to 0. It does not change on any other tick.
- R5: The seconds field `timer[31:25]` rises by one in the same update in which the count returns from 7999 to 0. From 127 it returns to 0.
- R6: A clock with `load` high writes `load_data` into all three fields at once. `load` takes priority over `tick_en`.
- R7: On a load, an offset of 3072 or more is written as 0, and a count of 8000 or more is written as 0. Each field is clamped separately and the other fields load unchanged.
- R8: `cycle_start` is high for exactly the one clock in which `timer` first shows offset 0 after a ticked wrap. A load never raises it.
- R9: `second_start` is high for exactly the one clock in which `timer` first shows count 0 after a ticked count wrap. A load never raises it.
- R10: On every tick without a load, the linear tick equivalent offset + 3072 * count + 24,576,000 * seconds rises by exactly one, modulo 128 * 24,576,000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Time base tick, one clock wide |
| load | input | 1 | Write strobe for the whole word |
| load_data | input | 32 | Word to load: seconds [31:25], count [24:12], offset [11:0] |
| timer | output | 32 | Packed timer word |
| cycle_start | output | 1 | One-clock pulse at an offset wrap |
| second_start | output | 1 | One-clock pulse at a count wrap |

## Verification
Each result is due one clock edge after its stimulus. The word, both boundary pulses, a load and a clamp all appear together after the single edge at which the inputs are taken. The bench drives inputs on the falling edge, updates its arithmetic model at the rising edge, and samples all outputs one nanosecond later. The pulses are therefore compared in the same cycle as the field values they flag. Sweeps over every offset, and loads on both sides of each clamp limit, check the carries and the clamping in that same cycle.

// File: rtl/bct_pkg.sv
package bct_pkg;
   // default field layout of the packed timer word
   localparam int DEF_OFF_W   = 12;
   localparam int DEF_OFF_MOD = 3072;
   localparam int DEF_CNT_W   = 13;
   localparam int DEF_CNT_MOD = 8000;
   localparam int DEF_SEC_W   = 7;
   localparam int DEF_SEC_MOD = 128;
   localparam int NUM_FIELDS  = 3;
endpackage

// File: rtl/bct_digit.sv
module bct_digit #(
   parameter int W   = 12,
   parameter int MOD = 3072
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] value,
   output logic         at_top
);
   localparam logic [W-1:0] TOP = W'(MOD - 1);

   generate
      if (MOD < 2 || MOD > (1 << W)) begin : g_bad_mod
         $error("bct_digit: MOD must lie in 2..2**W");
      end
   endgenerate

   logic [W-1:0] load_fix;

   generate
      if (MOD == (1 << W)) begin : g_full
         assign load_fix = load_val;
      end else begin : g_clamp
         assign load_fix = (load_val > TOP) ? '0 : load_val;
      end
   endgenerate

   assign at_top = (value == TOP);

   always_ff @(posedge clk) begin
      if (rst)       value <= '0;
      else if (load) value <= load_fix;
      else if (step) value <= at_top ? '0 : value + 1'b1;
   end

   assert_in_range_R7: assert property (@(posedge clk) disable iff (rst)
      value <= TOP);
   assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (step && !load && at_top) |=> (value == '0));
   assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
      (step && !load && !at_top) |=> (value == $past(value) + 1'b1));
   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(value));
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
   import bct_pkg::*;
#(
   parameter int OFF_W   = DEF_OFF_W,
   parameter int OFF_MOD = DEF_OFF_MOD,
   parameter int CNT_W   = DEF_CNT_W,
   parameter int CNT_MOD = DEF_CNT_MOD,
   parameter int SEC_W   = DEF_SEC_W,
   parameter int TW      = OFF_W + CNT_W + SEC_W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick_en,
   input  logic          load,
   input  logic [TW-1:0] load_data,
   output logic [TW-1:0] timer,
   output logic          cycle_start,
   output logic          second_start
);
   localparam int SEC_MOD = 1 << SEC_W;
   localparam int WID [NUM_FIELDS] = '{OFF_W, CNT_W, SEC_W};
   localparam int MODS[NUM_FIELDS] = '{OFF_MOD, CNT_MOD, SEC_MOD};
   localparam int LSB [NUM_FIELDS] = '{0, OFF_W, OFF_W + CNT_W};

   generate
      if (TW != OFF_W + CNT_W + SEC_W) begin : g_bad_tw
         $error("bus_cycle_timer: TW must equal the sum of field widths");
      end
   endgenerate

   logic [NUM_FIELDS-1:0] stp;
   logic [NUM_FIELDS-1:0] top;

   // carry chain: each field steps on a tick that finds every lower field at its top
   assign stp[0] = tick_en;

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         if (i > 0) begin : g_carry
            assign stp[i] = stp[i-1] & top[i-1];
         end
         bct_digit #(.W(WID[i]), .MOD(MODS[i])) u_digit (
            .clk      (clk),
            .rst      (rst),
            .step     (stp[i]),
            .load     (load),
            .load_val (load_data[LSB[i] +: WID[i]]),
            .value    (timer[LSB[i] +: WID[i]]),
            .at_top   (top[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cycle_start  <= 1'b0;
         second_start <= 1'b0;
      end else begin
         cycle_start  <= stp[1] & ~load;
         second_start <= stp[2] & ~load;
      end
   end

   wire [OFF_W-1:0] off_f = timer[OFF_W-1:0];
   wire [CNT_W-1:0] cnt_f = timer[OFF_W +: CNT_W];

   assert_same_update_R4: assert property (@(posedge clk) disable iff (rst)
      (tick_en && !load && off_f == OFF_W'(OFF_MOD - 1)) |=>
      (off_f == '0 && (cnt_f == CNT_W'(($past(cnt_f) == CNT_W'(CNT_MOD - 1)) ? 0 : $past(cnt_f) + 1))));
   assert_count_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!load && off_f != OFF_W'(OFF_MOD - 1)) |=> $stable(cnt_f));
   assert_cycle_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      cycle_start |-> (off_f == '0));
   assert_second_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      second_start |-> (cycle_start && cnt_f == '0));
   assert_no_pulse_on_load_R6: assert property (@(posedge clk) disable iff (rst)
      load |=> !cycle_start);
endmodule

// File: tb/sim_bus_cycle_timer.sv
module sim_bus_cycle_timer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_en = 1'b0;
   logic        load = 1'b0;
   logic [31:0] load_data = '0;
   logic [31:0] timer;
   logic        cycle_start, second_start;

   int total = 0;
   int bad = 0;
   int eo = 0, ec = 0, es = 0;
   bit ecs = 0, ess = 0;
   longint prev_lin = 0;
   localparam longint FULL = 64'd3072 * 64'd8000 * 64'd128;

   always #2.5 clk = ~clk;

   bus_cycle_timer u0 (
      .clk(clk), .rst(rst), .tick_en(tick_en), .load(load),
      .load_data(load_data), .timer(timer),
      .cycle_start(cycle_start), .second_start(second_start)
   );

   function automatic longint lin(input logic [31:0] w);
      return longint'(w[11:0]) + 64'd3072 * longint'(w[24:12])
           + 64'd24576000 * longint'(w[31:25]);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input bit t, input bit l, input logic [31:0] d, input string req);
      @(negedge clk);
      tick_en = t; load = l; load_data = d;
      prev_lin = lin(timer);
      @(posedge clk);
      ecs = 0; ess = 0;
      if (l) begin
         eo = (int'(d[11:0]) >= 3072) ? 0 : int'(d[11:0]);
         ec = (int'(d[24:12]) >= 8000) ? 0 : int'(d[24:12]);
         es = int'(d[31:25]);
      end else if (t) begin
         eo++;
         if (eo == 3072) begin
            eo = 0; ecs = 1; ec++;
            if (ec == 8000) begin
               ec = 0; ess = 1; es = (es + 1) % 128;
            end
         end
      end
      #1;
      chk(int'(timer[11:0]) == eo, {req, " offset"}, longint'(timer[11:0]), longint'(eo));
      chk(int'(timer[24:12]) == ec, {req, " count"}, longint'(timer[24:12]), longint'(ec));
      chk(int'(timer[31:25]) == es, {req, " seconds"}, longint'(timer[31:25]), longint'(es));
      chk(cycle_start == ecs, "R8 cycle_start", longint'(cycle_start), longint'(ecs));
      chk(second_start == ess, "R9 second_start", longint'(second_start), longint'(ess));
      if (t && !l)
         chk(lin(timer) == (prev_lin + 1) % FULL, "R10 linear step", lin(timer), (prev_lin + 1) % FULL);
   endtask

   function automatic logic [31:0] pack(input int s, input int c, input int o);
      return {s[6:0], c[12:0], o[11:0]};
   endfunction

   initial begin
      #950000;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state, even with ticks and loads asserted
      @(negedge clk); tick_en = 1; load = 1; load_data = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      #1;
      chk(timer == 32'd0, "R1 timer", longint'(timer), 0);
      chk(!cycle_start && !second_start, "R1 pulses", longint'({cycle_start, second_start}), 0);
      @(negedge clk); rst = 0; tick_en = 0; load = 0;

      // R2 R4 R8: every offset through two full cycles
      for (int i = 0; i < 2 * 3072 + 5; i++) cyc(1, 0, '0, "R2");

      // R3: idle cycles hold the word and raise no pulse
      for (int i = 0; i < 20; i++) cyc(0, 0, '0, "R3");
      // R3 ticks interleaved with idle clocks
      for (int i = 0; i < 40; i++) cyc(i % 3 == 0, 0, '0, "R3");

      // R4 R5 R9: count wrap and seconds step, across several seconds values
      for (int s = 0; s < 128; s += 37) begin
         cyc(0, 1, pack(s, 7999, 3069), "R6");
         for (int i = 0; i < 6; i++) cyc(1, 0, '0, "R4");
      end

      // R5: full word wrap back to zero
      cyc(0, 1, pack(127, 7999, 3070), "R6");
      for (int i = 0; i < 4; i++) cyc(1, 0, '0, "R5");

      // R6: load beats tick, no pulse even when loading at a boundary
      cyc(1, 1, pack(5, 100, 3071), "R6");
      cyc(1, 1, pack(9, 7999, 0), "R6");
      cyc(1, 0, '0, "R6");

      // R7: offset clamp sweep, both sides of the limit
      for (int o = 3060; o < 4096; o++) cyc(o[0], 1, pack(3, 17, o), "R7");
      // R7: count clamp sweep, both sides of the limit
      for (int c = 7990; c < 8192; c++) cyc(0, 1, pack(64, c, 12), "R7");
      cyc(0, 1, 32'hFFFF_FFFF, "R7");
      for (int i = 0; i < 4; i++) cyc(1, 0, '0, "R10");

      // R1: reset mid-run clears everything again
      @(negedge clk); rst = 1;
      @(posedge clk); #1;
      eo = 0; ec = 0; es = 0;
      chk(timer == 32'd0, "R1 reset mid-run", longint'(timer), 0);
      @(negedge clk); rst = 0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule